// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt requests from five sources (two external event lines, two timer overflows and the serial port) and presents at most one of them at a time to a processor core. Each source can be switched on or off on its own, and a global switch gates all of them. A priority register places every source at either the low or the high level. Among pending, enabled requests the block picks one by level first and then by a fixed polling order. It offers the winner's fixed handler address together with a valid strobe, and the core takes it with an acknowledge.

The block also keeps track of which levels are in service. A high-level request may interrupt a running low-level handler. While a high-level handler runs, nothing is offered. While only a low-level handler runs, only high-level requests are offered. A return pulse from the core ends the innermost handler. Clearing of the request flags is left to the sources and the core.

Configuration uses a single write port: `cfg_sel` = 0 writes the enable register and `cfg_sel` = 1 writes the priority register. Source index i is 0 for external 0, 1 for timer 0, 2 for external 1, 3 for timer 1 and 4 for serial. This index gives the bit position in both registers and the position on `irq_req`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable and priority registers are zero, `irq_valid` is 0 and `svc_active` is 2'b00, whatever `irq_req` carries.
- R2: Enable bit 7 is the global switch. While it is 0, no request is offered, even when its own enable bit is set.
- R3: Enable bit i (0 to 4) lets source i take part in arbitration. A source whose bit is 0 is never offered.
- R4: The offered vector for source i is 16'h0003 + 8*i: 0003h, 000Bh, 0013h, 001Bh or 0023h.
- R5: Among pending, enabled requests at the same level, the lowest source index wins.
- R6: A pending high-level request (priority bit i = 1) wins over any pending low-level request, whatever their polling positions.
- R7: While only a low-level handler is in service, a high-level request is offered. Accepting it sets `svc_active[1]` and keeps `svc_active[0]`.
- R8: No low-level request is offered while any handler is in service.
- R9: No request is offered while a high-level handler is in service, including other high-level requests.
- R10: `irq_valid`/`irq_vector`/`irq_level` are registered and change one clock after the request and configuration that select them. An `irq_ack` while `irq_valid` is 1 clears `irq_valid` on the next clock and marks the offered level in service. An `irq_ack` while `irq_valid` is 0 has no effect.
- R11: An `irq_reti` pulse clears the high in-service bit if it is set, and otherwise the low one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 5 | Request lines, index 0 to 4 in polling order |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the enable register, 1 selects the priority register |
| cfg_wdata | input | 8 | Configuration write data |
| irq_ack | input | 1 | Core accepts the offered interrupt |
| irq_reti | input | 1 | Core returns from the current handler |
| irq_valid | output | 1 | An interrupt is offered |
| irq_vector | output | 16 | Handler address of the offered interrupt |
| irq_level | output | 1 | Level of the offered interrupt (1 = high) |
| svc_active | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
The bench first raises all five lines at once with one source enabled at a time. This ties each enable bit to its own vector and shows that neither the bit order nor the vector spacing is skewed. Sparse request patterns at a single level then show whether the polling order picks the lowest index rather than the highest or the most recent. Priority settings that lift a late-polled source above an earlier one separate arbitration by level from plain polling order. An accept, nest, return sequence with requests held active checks that preemption follows the in-service state and that each return ends the correct level.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC  = 5;
    localparam int DATA_W   = 8;
    localparam int VEC_W    = 16;
    localparam int VEC_BASE = 3;
    localparam int VEC_STEP = 8;
    localparam int GLB_BIT  = 7;
    localparam int IDX_W    = $clog2(NUM_SRC);

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } irq_lvl_e;

    typedef struct packed {
        logic               valid;
        logic [VEC_W-1:0]   vector;
        irq_lvl_e           level;
    } offer_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } svc_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int DW = DATA_W,
    parameter int GB = GLB_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  hi_req,
    output logic [N-1:0]  lo_req
);
    typedef struct packed {
        logic          glb;
        logic [N-1:0]  en;
        logic [N-1:0]  pri;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [N-1:0] live;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            if (cfg_sel) begin
                cfg_d.pri = cfg_wdata[N-1:0];
            end else begin
                cfg_d.en  = cfg_wdata[N-1:0];
                cfg_d.glb = cfg_wdata[GB];
            end
        end
        live   = req & cfg_q.en & {N{cfg_q.glb}};
        hi_req = live & cfg_q.pri;
        lo_req = live & ~cfg_q.pri;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // R3: an enable write lands in the register one clock later
    assert_enable_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we && !cfg_sel && rst_n) |-> cfg_q.en == $past(cfg_wdata[N-1:0]));

    // R2: nothing reaches arbitration with the global switch off
    assert_global_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.glb |-> (hi_req == '0 && lo_req == '0));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  hi_req,
    input  logic [N-1:0]  lo_req,
    output logic          grant_valid,
    output irq_lvl_e      grant_lvl,
    output logic [IW-1:0] grant_idx
);
    localparam int RES_W = IW + 1;

    function automatic logic [RES_W-1:0] first_set(input logic [N-1:0] v);
        logic [RES_W-1:0] r;
        r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (v[i]) r = {1'b1, IW'(i)};
        end
        return r;
    endfunction

    logic [RES_W-1:0] lvl_res [2];

    generate
        for (genvar lv = 0; lv < 2; lv++) begin : g_level
            if (lv == 1) begin : g_hi
                assign lvl_res[lv] = first_set(hi_req);
            end else begin : g_lo
                assign lvl_res[lv] = first_set(lo_req);
            end
        end
    endgenerate

    always_comb begin
        if (lvl_res[1][IW]) begin
            grant_valid = 1'b1;
            grant_lvl   = LVL_HI;
            grant_idx   = lvl_res[1][IW-1:0];
        end else begin
            grant_valid = lvl_res[0][IW];
            grant_lvl   = LVL_LO;
            grant_idx   = lvl_res[0][IW-1:0];
        end
    end

    // R6: a pending high request always takes the grant
    assert_high_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_req != '0) |-> (grant_valid && grant_lvl == LVL_HI));

    // R5: the granted source is actually requesting at the granted level
    assert_grant_real_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_lvl == LVL_HI ? hi_req[grant_idx] : lo_req[grant_idx]));
endmodule

// File: rtl/irq_nest.sv
module irq_nest
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  irq_lvl_e push_lvl,
    input  logic     pop,
    output svc_t     svc
);
    svc_t svc_d, svc_q;

    always_comb begin
        svc_d = svc_q;
        if (pop) begin
            if (svc_q.hi) svc_d.hi = 1'b0;
            else          svc_d.lo = 1'b0;
        end
        if (push) begin
            if (push_lvl == LVL_HI) svc_d.hi = 1'b1;
            else                    svc_d.lo = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= svc_d;
    end

    assign svc = svc_q;

    // R10: a level enters service only through an accepted offer
    assert_hi_enter_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_q.hi) |-> $past(push && push_lvl == LVL_HI));

    // R11: the low level leaves service only when no high handler was active
    assert_lo_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(svc_q.lo) |-> $past(pop && !svc_q.hi));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       irq_req,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [7:0]       cfg_wdata,
    input  logic             irq_ack,
    input  logic             irq_reti,
    output logic             irq_valid,
    output logic [15:0]      irq_vector,
    output logic             irq_level,
    output logic [1:0]       svc_active
);
    logic [NUM_SRC-1:0] hi_req, lo_req;
    logic               grant_valid;
    irq_lvl_e           grant_lvl;
    logic [IDX_W-1:0]   grant_idx;
    svc_t               svc;
    offer_t             off_d, off_q;
    logic               accept, take;

    irq_cfg_regs #(.N(NUM_SRC), .DW(DATA_W), .GB(GLB_BIT)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .req       (irq_req),
        .hi_req    (hi_req),
        .lo_req    (lo_req)
    );

    irq_arbiter #(.N(NUM_SRC), .IW(IDX_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .hi_req      (hi_req),
        .lo_req      (lo_req),
        .grant_valid (grant_valid),
        .grant_lvl   (grant_lvl),
        .grant_idx   (grant_idx)
    );

    irq_nest u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_lvl (off_q.level),
        .pop      (irq_reti),
        .svc      (svc)
    );

    always_comb begin
        accept = irq_ack && off_q.valid;
        // high level may preempt low; nothing preempts high
        take = grant_valid && !svc.hi && (grant_lvl == LVL_HI || !svc.lo);
        off_d.valid  = take && !accept;
        off_d.vector = VEC_W'(VEC_BASE) + VEC_W'(grant_idx) * VEC_W'(VEC_STEP);
        off_d.level  = grant_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= off_d;
    end

    assign irq_valid  = off_q.valid;
    assign irq_vector = off_q.vector;
    assign irq_level  = off_q.level;
    assign svc_active = {svc.hi, svc.lo};

    // R9: a running high handler silences the controller
    assert_no_offer_high_svc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        svc.hi |-> !off_q.valid);

    // R8: under a low handler only high requests may be offered
    assert_low_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (svc.lo && off_q.valid) |-> off_q.level == LVL_HI);

    // R4: every offered vector is one of the five handler slots
    assert_vector_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        off_q.valid |-> (off_q.vector[2:0] == 3'd3 && off_q.vector <= 16'h0023));

    // R10: an accepted offer is withdrawn on the next clock
    assert_ack_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && off_q.valid) |=> !off_q.valid);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  irq_req;
    logic        cfg_we, cfg_sel;
    logic [7:0]  cfg_wdata;
    logic        irq_ack, irq_reti;
    logic        irq_valid;
    logic [15:0] irq_vector;
    logic        irq_level;
    logic [1:0]  svc_active;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic        valid;
        logic [15:0] vector;
        logic [1:0]  svc;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req    (irq_req),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .irq_ack    (irq_ack),
        .irq_reti   (irq_reti),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector),
        .irq_level  (irq_level),
        .svc_active (svc_active)
    );

    // monitor: compares queued expectations after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (irq_valid !== e.valid || svc_active !== e.svc ||
                    (e.valid && irq_vector !== e.vector)) begin
                    errors++;
                    $display("FAIL %s: got valid=%0b vec=%h svc=%b, expected valid=%0b vec=%h svc=%b",
                             e.tag, irq_valid, irq_vector, svc_active, e.valid, e.vector, e.svc);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input logic v, input logic [15:0] vec,
                              input logic [1:0] s, input string tag);
        exp_t e;
        e.valid = v; e.vector = vec; e.svc = s; e.tag = tag;
        exp_q.push_back(e);
        #3;
    endtask

    task automatic wr_cfg(input logic sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic pulse_reti();
        irq_reti = 1'b1; step(); irq_reti = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_req = 5'h1F; cfg_we = 1'b0; cfg_sel = 1'b0;
        cfg_wdata = '0; irq_ack = 1'b0; irq_reti = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_out(1'b0, 16'h0, 2'b00, "R1 reset state");
        step(); step();
        expect_out(1'b0, 16'h0, 2'b00, "R1 all requests, nothing enabled");

        wr_cfg(1'b0, 8'h1F); step();
        expect_out(1'b0, 16'h0, 2'b00, "R2 sources on, global off");

        // R3/R4: one source at a time with all lines raised
        for (int i = 0; i < 5; i++) begin
            wr_cfg(1'b0, 8'h80 | (8'h01 << i)); step();
            expect_out(1'b1, 16'h0003 + 16'(8 * i), 2'b00, $sformatf("R3 R4 source %0d vector", i));
        end

        // R5: same-level polling
        wr_cfg(1'b0, 8'h9F);
        irq_req = 5'b10110; step();
        expect_out(1'b1, 16'h000B, 2'b00, "R5 lowest index among 10110");
        irq_req = 5'b11000; step();
        expect_out(1'b1, 16'h001B, 2'b00, "R5 lowest index among 11000");

        // R6: level beats polling order
        irq_req = 5'h1F;
        wr_cfg(1'b1, 8'h10); step();
        expect_out(1'b1, 16'h0023, 2'b00, "R6 serial high over all low");
        wr_cfg(1'b1, 8'h14); step();
        expect_out(1'b1, 16'h0013, 2'b00, "R6 polling among two high");

        // R10: ack with nothing offered is ignored
        wr_cfg(1'b1, 8'h00);
        irq_req = 5'b00000; step();
        expect_out(1'b0, 16'h0, 2'b00, "R10 idle with no requests");
        pulse_ack();
        expect_out(1'b0, 16'h0, 2'b00, "R10 stray ack has no effect");

        // R10/R8: accept a low request, then low stays blocked
        irq_req = 5'b00001; step();
        expect_out(1'b1, 16'h0003, 2'b00, "R10 offer after request");
        pulse_ack();
        expect_out(1'b0, 16'h0, 2'b01, "R10 ack clears offer, low in service");
        irq_req = 5'b00101; step(); step();
        expect_out(1'b0, 16'h0, 2'b01, "R8 low requests blocked in service");

        // R7: high preempts low
        irq_req = 5'b11101;
        wr_cfg(1'b1, 8'h08); step();
        expect_out(1'b1, 16'h001B, 2'b01, "R7 high offered over low handler");
        pulse_ack();
        expect_out(1'b0, 16'h0, 2'b11, "R7 nested high in service");

        // R9: another high is not offered
        wr_cfg(1'b1, 8'h18); step(); step();
        expect_out(1'b0, 16'h0, 2'b11, "R9 high handler not preempted");

        // R11: returns unwind high first, then low
        pulse_reti();
        expect_out(1'b0, 16'h0, 2'b01, "R11 return ends high level");
        step();
        expect_out(1'b1, 16'h001B, 2'b01, "R7 high offered again after return");
        irq_req = 5'b00000; step();
        expect_out(1'b0, 16'h0, 2'b01, "R10 offer follows withdrawn request");
        pulse_reti();
        expect_out(1'b0, 16'h0, 2'b00, "R11 return ends low level");

        // R2: turning the global switch off withdraws an offer
        irq_req = 5'b00001; step();
        expect_out(1'b1, 16'h0003, 2'b00, "R2 offer with global on");
        wr_cfg(1'b0, 8'h1F); step();
        expect_out(1'b0, 16'h0, 2'b00, "R2 offer withdrawn with global off");

        step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule